// File: doc/BRIEF.md
# Vector-to-SIMD Issue Packer

This block sits in the stage right after instruction decode. It takes one vector operation, described by a vector length (VL) and an element-width override, and turns it into a stream of issue packets for a pool of 64-bit SIMD ALU slots. Each packet names the first element it covers, how many lanes it uses and which lanes are live.

When the elements are narrow (8, 16 or 32 bits), several consecutive elements share one ALU issue. With 64-bit elements, each ALU receives a single element. Each slot reports whether it is free. In every cycle the packer hands out packets to the free slots, lowest-numbered first. Any elements left over wait for a later cycle.

A new instruction is taken only after every element of the current one has gone out. The `in_ready` output signals this.

Top module: `simd_issue_packer`

## Requirements
- R1: The width code `in_ew` selects the lanes per packet as 0 → 8 lanes (8-bit), 1 → 4 lanes (16-bit), 2 → 2 lanes (32-bit) and 3 → 1 lane (64-bit). Every packet except the final one of an instruction carries exactly that many lanes.
- R2: Packets go only to slots whose `alu_free` bit is 1. Within a cycle, the packets fill the free slots from slot 0 upward, and no free slot is skipped while elements remain.
- R3: Element indices are consecutive. The k-th packet of a cycle (counting from 0) starts at the first unissued element plus k times the lane count.
- R4: The lane mask of a packet has its lowest `iss_lanes` bits set and all other bits clear. The last packet is partial when VL is not a multiple of the lane count.
- R5: Elements that do not fit in the free slots carry over to the next cycle. With no slot free, nothing is issued and the instruction stays pending.
- R6: `in_ready` is low from the cycle after acceptance until the cycle after the last packet. An `in_valid` presented while `in_ready` is low is ignored. No packet is issued while `in_ready` is high.
- R7: An instruction with VL = 0 issues no packet, and `in_ready` is high again in the following cycle.
- R8: After reset, `in_ready` is high and no packet is valid.
- R9: Over one instruction, the packets cover elements 0 to VL−1, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded vector instruction present |
| in_vl | input | VL_W | Vector length |
| in_ew | input | 2 | Element width code (see R1) |
| in_ready | output | 1 | Block can accept an instruction |
| alu_free | input | N_ALU | Per-slot free flag |
| iss_valid | output | N_ALU | Per-slot packet valid |
| iss_start | output | N_ALU*VL_W | Per-slot first element index |
| iss_lanes | output | N_ALU*CNT_W | Per-slot lane count |
| iss_mask | output | N_ALU*MAXL | Per-slot live-lane mask |

## Verification
The bench targets several corner cases:
- A VL that is not a multiple of the lane count. A design that gets this wrong would emit a full mask or a lane past the end of the vector.
- Sparse free-slot patterns. A wrong design would put a packet on a busy slot, or leave a low free slot idle.
- A run of cycles with no free slot, during which a second instruction is offered. A wrong design would lose elements or accept the stray instruction.
- The largest VL and VL = 0. These expose counter wrap and a missing single-cycle return to ready.

// File: rtl/simd_issue_packer.sv
module simd_issue_packer #(
  parameter int N_ALU = 4,
  parameter int VL_W  = 7,
  parameter int ALU_W = 64,
  localparam int MAXL  = ALU_W / 8,
  localparam int CNT_W = $clog2(MAXL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [VL_W-1:0]        in_vl,
  input  logic [1:0]             in_ew,
  output logic                   in_ready,
  input  logic [N_ALU-1:0]       alu_free,
  output logic [N_ALU-1:0]       iss_valid,
  output logic [N_ALU*VL_W-1:0]  iss_start,
  output logic [N_ALU*CNT_W-1:0] iss_lanes,
  output logic [N_ALU*MAXL-1:0]  iss_mask
);
  localparam int SW = VL_W + $clog2(N_ALU * MAXL + 1) + 1;

  logic            busy;
  logic [VL_W-1:0] vl_q, next_q;
  logic [1:0]      ew_q;
  logic [SW-1:0]   lanes, taken, pos, left, cnt;
  logic            fin;

  assign in_ready = !busy;
  assign lanes    = SW'(MAXL) >> ew_q;

  always_comb begin
    taken     = '0;
    pos       = '0;
    left      = '0;
    cnt       = '0;
    iss_valid = '0;
    iss_start = '0;
    iss_lanes = '0;
    iss_mask  = '0;
    for (int i = 0; i < N_ALU; i++) begin
      pos = SW'(next_q) + taken;
      if (busy && alu_free[i] && pos < SW'(vl_q)) begin
        left = SW'(vl_q) - pos;
        cnt  = (left < lanes) ? left : lanes;
        iss_valid[i] = 1'b1;
        iss_start[i*VL_W +: VL_W]   = pos[VL_W-1:0];
        iss_lanes[i*CNT_W +: CNT_W] = cnt[CNT_W-1:0];
        for (int j = 0; j < MAXL; j++)
          iss_mask[i*MAXL + j] = SW'(j) < cnt;
        taken = taken + cnt;
      end
    end
  end

  assign fin = busy && (SW'(next_q) + taken >= SW'(vl_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      vl_q   <= '0;
      ew_q   <= '0;
      next_q <= '0;
    end else if (in_valid && !busy) begin
      vl_q   <= in_vl;
      ew_q   <= in_ew;
      next_q <= '0;
      busy   <= in_vl != '0;
    end else if (busy) begin
      next_q <= next_q + taken[VL_W-1:0];
      if (fin) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_issue_packer_chk.sv
module simd_issue_packer_chk #(
  parameter int N_ALU = 4,
  parameter int VL_W  = 7,
  parameter int ALU_W = 64,
  localparam int MAXL  = ALU_W / 8,
  localparam int CNT_W = $clog2(MAXL + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [VL_W-1:0]        in_vl,
  input logic [1:0]             in_ew,
  input logic                   in_ready,
  input logic [N_ALU-1:0]       alu_free,
  input logic [N_ALU-1:0]       iss_valid,
  input logic [N_ALU*VL_W-1:0]  iss_start,
  input logic [N_ALU*CNT_W-1:0] iss_lanes,
  input logic [N_ALU*MAXL-1:0]  iss_mask
);
  logic [1:0] cur_ew;
  always_ff @(posedge clk)
    if (!rst_n) cur_ew <= '0;
    else if (in_valid && in_ready) cur_ew <= in_ew;

  p_only_free_alus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & ~alu_free) == '0);

  p_idle_no_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> iss_valid == '0);

  p_zero_vl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_vl == '0) |=> in_ready);

  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && alu_free == '0) |=> !in_ready);

  for (genvar g = 0; g < N_ALU; g++) begin : g_slot
    logic [MAXL-1:0]  m;
    logic [CNT_W-1:0] c;
    assign m = iss_mask[g*MAXL +: MAXL];
    assign c = iss_lanes[g*CNT_W +: CNT_W];

    p_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[g] |-> ($countones(m) == int'(c) && (m & (m + 1'b1)) == '0));

    p_lane_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[g] |-> (c != '0 && int'(c) <= (MAXL >> cur_ew)));

    p_lowest_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[g] |-> ((alu_free & ~iss_valid & N_ALU'((1 << g) - 1)) == '0));
  end
endmodule

bind simd_issue_packer simd_issue_packer_chk #(
  .N_ALU(N_ALU), .VL_W(VL_W), .ALU_W(ALU_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vl(in_vl), .in_ew(in_ew),
  .in_ready(in_ready), .alu_free(alu_free), .iss_valid(iss_valid),
  .iss_start(iss_start), .iss_lanes(iss_lanes), .iss_mask(iss_mask)
);

// File: tb/sim_simd_issue_packer.sv
module sim_simd_issue_packer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, VW = 7, ML = 8, CW = 4;

  logic clk = 0, rst_n = 0, in_valid = 0, in_ready;
  logic [VW-1:0] in_vl = '0;
  logic [1:0] in_ew = '0;
  logic [N-1:0] alu_free = '0, iss_valid;
  logic [N*VW-1:0] iss_start;
  logic [N*CW-1:0] iss_lanes;
  logic [N*ML-1:0] iss_mask;

  int total = 0, fails = 0, m_vl = 0, m_ew = 0, m_next = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_issue_packer #(.N_ALU(N), .VL_W(VW), .ALU_W(64)) u0 (.*);

  // ew[18:17] vl[16:10] free[9:6] cycles[5:0]
  localparam logic [18:0] VEC [8] = '{
    {2'd1, 7'd8,   4'b0011, 6'd1},
    {2'd0, 7'd20,  4'b1111, 6'd1},
    {2'd3, 7'd6,   4'b1010, 6'd3},
    {2'd2, 7'd5,   4'b0100, 6'd3},
    {2'd1, 7'd1,   4'b1000, 6'd1},
    {2'd0, 7'd127, 4'b1111, 6'd4},
    {2'd3, 7'd9,   4'b1111, 6'd3},
    {2'd2, 7'd0,   4'b1111, 6'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2 R3 R4 R1: compare one cycle's packets with the model
  task automatic step_check();
    int rank = 0, lanes = 8 >> m_ew, issued = 0;
    for (int i = 0; i < N; i++) begin
      int st = m_next + rank * lanes;
      bit ev = alu_free[i] && st < m_vl;
      int c = ev ? ((m_vl - st < lanes) ? m_vl - st : lanes) : 0;
      chk(iss_valid[i] == ev, "R2 valid", int'(iss_valid[i]), int'(ev));
      if (ev) begin
        chk(int'(iss_start[i*VW +: VW]) == st, "R3 start", int'(iss_start[i*VW +: VW]), st);
        chk(int'(iss_lanes[i*CW +: CW]) == c, "R1 lanes", int'(iss_lanes[i*CW +: CW]), c);
        chk(int'(iss_mask[i*ML +: ML]) == (1 << c) - 1, "R4 mask",
            int'(iss_mask[i*ML +: ML]), (1 << c) - 1);
        issued += c;
      end
      if (alu_free[i]) rank++;
    end
    m_next += issued;
  endtask

  task automatic start_instr(input int ew, input int vl);
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R6 ready before accept", int'(in_ready), 1);
    in_valid = 1; in_vl = VW'(vl); in_ew = 2'(ew);
    m_vl = vl; m_ew = ew; m_next = 0;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_vec(input int ew, input int vl, input logic [3:0] free, input int exp_cyc);
    int cyc = 0;
    start_instr(ew, vl);
    for (int k = 0; k < 300; k++) begin
      alu_free = free;
      #1;
      if (in_ready) break;
      step_check();
      cyc++;
      @(negedge clk);
    end
    chk(cyc == exp_cyc, "R5 cycles to finish", cyc, exp_cyc);
    chk(m_next == vl, "R9 elements covered", m_next, vl);
    if (vl == 0) chk(in_ready && iss_valid == 0, "R7 zero length", int'(iss_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R8 ready in reset", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);
    chk(iss_valid == 0, "R8 no packet after reset", int'(iss_valid), 0);

    for (int v = 0; v < 8; v++)
      run_vec(int'(VEC[v][18:17]), int'(VEC[v][16:10]), VEC[v][9:6], int'(VEC[v][5:0]));

    // R5 stall with no slot free, R6 stray instruction ignored
    start_instr(1, 8);
    for (int k = 0; k < 3; k++) begin
      alu_free = 4'b0000;
      in_valid = 1; in_vl = 7'd3; in_ew = 2'd3;
      #1;
      chk(iss_valid == 0, "R5 no issue while stalled", int'(iss_valid), 0);
      chk(in_ready == 0, "R6 busy while stalled", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 0;
    for (int k = 0; k < 2; k++) begin
      alu_free = 4'b0001;
      #1;
      step_check();
      @(negedge clk);
    end
    #1;
    chk(in_ready == 1, "R6 ready after last packet", int'(in_ready), 1);
    chk(m_next == 8, "R9 stall run covered", m_next, 8);

    // R5 free pattern changes mid-instruction
    start_instr(3, 5);
    alu_free = 4'b1111;
    #1;
    step_check();
    @(negedge clk);
    alu_free = 4'b0110;
    #1;
    step_check();
    chk(iss_valid == 4'b0010, "R2 leftover on lowest free", int'(iss_valid), 2);
    @(negedge clk);
    #1;
    chk(in_ready == 1 && m_next == 5, "R9 changing pattern", m_next, 5);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule